// File: doc/BRIEF.md
# Five-Segment Open-Drain Bus Hub Repeater

This block joins five segments of a two-wire open-drain serial bus into one logical bus. Each segment carries a clock line and a data line. Each line appears at the block as a sampled input level and a pull-low request that drives an external open-drain pad. Clock and data each pass through an identical copy of the hub logic. A low that an outside device drives on any enabled segment is repeated onto every other enabled segment. Traffic between any two segments therefore crosses a single repeater stage. Because each line acts as a wired-AND across all segments, arbitration and clock stretching work through the hub.

The hub records which segments it is pulling low itself. The low it reads back from such a segment is not taken as a new source, so a forwarded low cannot hold the bus low after the real source lets go. The analog "pulled below the hub's own low level" detection is modelled by a separate contention input for each segment. When that input is set on a driven segment, the segment counts as a real source again.

Segments 1 to 4 can be enabled and disabled, while segment 0 is always active. A change of enable is held pending and is applied only when the bus is idle. The bus is idle when no START has been left open without a STOP, and the clock and data lines on all enabled segments have been high for `IDLE_CYC` cycles.

Top module: `hub_repeater`

## Requirements
- R1: Clock and data are independent. A low on a segment's clock line changes only `scl_pull`, and a low on its data line changes only `sda_pull`.
- R2: A low from an outside device on one enabled segment sets the pull bit of every other enabled segment, and does not set the pull bit of the source segment. Bit n of each vector is segment n.
- R3: While a segment is disabled, its pull bits stay 0 and its input levels have no effect on any output. Bit j of `en_req` controls segment j+1.
- R4: When several enabled segments are pulled low from outside at once, all of them are sources. The pull vector is the set of enabled segments minus the sources, which is all zero when every segment is a source.
- R5: A low the hub drives itself is never treated as a source. Once every outside low has gone, all pull bits return to 0 and stay 0, with no lock-up.
- R6: A segment the hub is driving, whose contention input is 1 while an outside device also holds it low, counts as a source. The hub keeps the other enabled segments low after the first source releases.
- R7: A change of an input level reaches the pull outputs on the third rising clock edge after it is applied: two synchronizer stages, then one output register.
- R8: A requested enable set is applied only after the clock and data lines on all enabled segments have been high for `IDLE_CYC` consecutive cycles. A request made while a line is held low stays pending.
- R9: During reset all pull bits are 0. After reset all five segments are enabled.
- R10: A START (data falling while clock is high on the combined bus) marks the bus busy, and enable requests are not applied until a STOP (data rising while clock is high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | NSEG | Sampled clock line level per segment |
| sda_in | input | NSEG | Sampled data line level per segment |
| scl_ext | input | NSEG | Clock line held low by an outside device while the hub drives it |
| sda_ext | input | NSEG | Data line held low by an outside device while the hub drives it |
| en_req | input | NSEG-1 | Requested enables for segments 1..NSEG-1 (bit j is segment j+1) |
| scl_pull | output | NSEG | Pull clock line of each segment low |
| sda_pull | output | NSEG | Pull data line of each segment low |

## Verification
The hardest situations to reach are the moments around a hand-over, when the line read back from a segment is low only because the hub drives it. The bench closes the loop the way a board does: each input level is the wired-AND of the bench's device lows and the hub's own pull bits. A source is then released and the bench confirms that the hub lets go and stays released. The contention input is set on a driven segment before the first source leaves, and the bench confirms that the drive is handed over to the new source without a gap. Gating of enable changes is reached by holding a line low, and also by leaving a START open with every line high, while an enable request waits. The bench then observes which segments are forwarded to.

// File: rtl/hub_pkg.sv
package hub_pkg;
    localparam int SEGMENTS     = 5;
    localparam int SYNC_DEPTH   = 2;
    localparam int IDLE_DEFAULT = 16;

    typedef enum logic {
        BUS_FREE = 1'b0,
        BUS_HELD = 1'b1
    } bus_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_pair_t;
endpackage

// File: rtl/hub_sync.sv
module hub_sync #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= {W{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hub_line.sv
module hub_line #(
    parameter int NSEG = 5,
    parameter int HOLD = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSEG-1:0] lvl,
    input  logic [NSEG-1:0] ext,
    input  logic [NSEG-1:0] en,
    output logic [NSEG-1:0] pull,
    output logic            src_any
);
    logic [NSEG-1:0] pull_q;
    logic [NSEG-1:0] own;
    logic [NSEG-1:0] src;
    logic [NSEG-1:0] nxt;
    logic [NSEG-1:0] trail [HOLD];

    // History of the hub's own drive, long enough to cover the input sync delay
    generate
        for (genvar g = 0; g < HOLD; g++) begin : g_trail
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) trail[0] <= '0;
                    else     trail[0] <= pull_q;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) trail[g] <= '0;
                    else     trail[g] <= trail[g-1];
                end
            end
        end
    endgenerate

    always_comb begin
        own = pull_q;
        for (int k = 0; k < HOLD; k++) own = own | trail[k];
    end

    assign src     = en & ((~lvl & ~own) | ext);
    assign src_any = |src;
    assign nxt     = src_any ? (en & ~src) : '0;

    always_ff @(posedge clk) begin
        if (rst) pull_q <= '0;
        else     pull_q <= nxt;
    end

    assign pull = pull_q;
endmodule

// File: rtl/hub_gate.sv
module hub_gate
    import hub_pkg::*;
#(
    parameter int NSEG     = 5,
    parameter int IDLE_CYC = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSEG-1:0] scl_s,
    input  logic [NSEG-1:0] sda_s,
    input  logic [NSEG-2:0] en_req,
    output logic [NSEG-1:0] en_app,
    output logic            gate_open
);
    localparam int CW = $clog2(IDLE_CYC + 1);

    logic [NSEG-1:1] en_q;
    logic            scl_all;
    logic            sda_all;
    logic            start;
    logic            stop;
    logic            quiet;
    line_pair_t      prev;
    bus_state_t      st;
    logic [CW-1:0]   cnt;

    assign en_app  = {en_q, 1'b1};
    assign scl_all = &(scl_s | ~en_app);
    assign sda_all = &(sda_s | ~en_app);

    assign start     = prev.scl & scl_all &  prev.sda & ~sda_all;
    assign stop      = prev.scl & scl_all & ~prev.sda &  sda_all;
    assign quiet     = scl_all & sda_all & (st == BUS_FREE);
    assign gate_open = quiet & (cnt == CW'(IDLE_CYC));

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '1;
            prev <= '{scl: 1'b1, sda: 1'b1};
            st   <= BUS_FREE;
            cnt  <= '0;
        end else begin
            prev <= '{scl: scl_all, sda: sda_all};
            if (start)     st <= BUS_HELD;
            else if (stop) st <= BUS_FREE;
            if (!quiet)          cnt <= '0;
            else if (!gate_open) cnt <= cnt + 1'b1;
            if (gate_open) en_q <= en_req;
        end
    end
endmodule

// File: rtl/hub_repeater.sv
module hub_repeater
    import hub_pkg::*;
#(
    parameter int NSEG     = SEGMENTS,
    parameter int SYNC     = SYNC_DEPTH,
    parameter int IDLE_CYC = IDLE_DEFAULT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSEG-1:0] scl_in,
    input  logic [NSEG-1:0] sda_in,
    input  logic [NSEG-1:0] scl_ext,
    input  logic [NSEG-1:0] sda_ext,
    input  logic [NSEG-2:0] en_req,
    output logic [NSEG-1:0] scl_pull,
    output logic [NSEG-1:0] sda_pull
);
    logic [2*NSEG-1:0] lvl_s;
    logic [2*NSEG-1:0] ext_s;
    logic [NSEG-1:0]   en_app;
    logic              gate_open;
    logic              scl_src_any;
    logic              sda_src_any;

    hub_sync #(.W(2*NSEG), .STAGES(SYNC), .RST_VAL(1'b1)) u_sync_lvl (
        .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(lvl_s)
    );

    hub_sync #(.W(2*NSEG), .STAGES(SYNC), .RST_VAL(1'b0)) u_sync_ext (
        .clk(clk), .rst(rst), .d({scl_ext, sda_ext}), .q(ext_s)
    );

    hub_gate #(.NSEG(NSEG), .IDLE_CYC(IDLE_CYC)) u_gate (
        .clk(clk), .rst(rst),
        .scl_s(lvl_s[2*NSEG-1:NSEG]), .sda_s(lvl_s[NSEG-1:0]),
        .en_req(en_req), .en_app(en_app), .gate_open(gate_open)
    );

    hub_line #(.NSEG(NSEG), .HOLD(SYNC)) u_scl (
        .clk(clk), .rst(rst),
        .lvl(lvl_s[2*NSEG-1:NSEG]), .ext(ext_s[2*NSEG-1:NSEG]), .en(en_app),
        .pull(scl_pull), .src_any(scl_src_any)
    );

    hub_line #(.NSEG(NSEG), .HOLD(SYNC)) u_sda (
        .clk(clk), .rst(rst),
        .lvl(lvl_s[NSEG-1:0]), .ext(ext_s[NSEG-1:0]), .en(en_app),
        .pull(sda_pull), .src_any(sda_src_any)
    );
endmodule

// File: rtl/hub_repeater_chk.sv
module hub_repeater_chk #(
    parameter int NSEG = 5
) (
    input logic            clk,
    input logic            rst,
    input logic [NSEG-1:0] scl_pull,
    input logic [NSEG-1:0] sda_pull,
    input logic [NSEG-1:0] en_app,
    input logic            gate_open,
    input logic            scl_src_any,
    input logic            sda_src_any
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R9
    always_ff @(posedge clk) begin
        if (rst_d) begin
            reset_quiet_chk: assert (scl_pull == '0 && sda_pull == '0)
                else $error("pull active right after reset");
        end
    end

    // R3
    disabled_undriven_chk: assert property (@(posedge clk) disable iff (rst)
        ((scl_pull | sda_pull) & ~$past(en_app)) == '0);

    // R4
    scl_leaves_source_chk: assert property (@(posedge clk) disable iff (rst)
        (|scl_pull) |-> ((scl_pull & $past(en_app)) != $past(en_app)));

    // R4
    sda_leaves_source_chk: assert property (@(posedge clk) disable iff (rst)
        (|sda_pull) |-> ((sda_pull & $past(en_app)) != $past(en_app)));

    // R5
    scl_release_chk: assert property (@(posedge clk) disable iff (rst)
        !scl_src_any |=> (scl_pull == '0));

    // R5
    sda_release_chk: assert property (@(posedge clk) disable iff (rst)
        !sda_src_any |=> (sda_pull == '0));

    // R8
    enable_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(en_app) |-> $past(gate_open));

    // R9
    seg0_always_on_chk: assert property (@(posedge clk) disable iff (rst)
        en_app[0]);
endmodule

bind hub_repeater hub_repeater_chk #(.NSEG(NSEG)) u_chk (
    .clk(clk), .rst(rst),
    .scl_pull(scl_pull), .sda_pull(sda_pull),
    .en_app(en_app), .gate_open(gate_open),
    .scl_src_any(scl_src_any), .sda_src_any(sda_src_any)
);

// File: tb/tb_hub_repeater.sv
module tb_hub_repeater;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] sda_dev = '0;
    logic [4:0] scl_dev = '0;
    logic [4:0] sda_ext = '0;
    logic [4:0] scl_ext = '0;
    logic [3:0] en_req  = 4'b1111;
    logic [4:0] sda_pull;
    logic [4:0] scl_pull;
    logic [4:0] sda_in;
    logic [4:0] scl_in;
    int total = 0;
    int bad   = 0;

    // wired-AND of outside devices and the hub's own drive
    assign sda_in = ~(sda_dev | sda_pull);
    assign scl_in = ~(scl_dev | scl_pull);

    always #2 clk = ~clk;

    hub_repeater dut (
        .clk(clk), .rst(rst),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_ext(scl_ext), .sda_ext(sda_ext),
        .en_req(en_req),
        .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    // {sda_dev, scl_dev, expected sda_pull, expected scl_pull}
    localparam logic [19:0] VEC [6] = '{
        {5'b00000, 5'b00000, 5'b00000, 5'b00000},
        {5'b00001, 5'b00000, 5'b11110, 5'b00000},
        {5'b00000, 5'b01000, 5'b00000, 5'b10111},
        {5'b10100, 5'b00000, 5'b01011, 5'b00000},
        {5'b00001, 5'b00010, 5'b11110, 5'b11101},
        {5'b11111, 5'b00000, 5'b00000, 5'b00000}
    };

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_seq();
        scl_dev = '0; sda_dev = '0; tick(6);
        sda_dev = 5'b00001; tick(8);
        sda_dev = '0; tick(8);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(4);
        chk("R9 reset sda", sda_pull, 5'b00000);
        chk("R9 reset scl", scl_pull, 5'b00000);
        rst = 1'b0;
        tick(4);
        // R9: all segments enabled after reset
        sda_dev = 5'b10000; tick(8);
        chk("R9 all enabled", sda_pull, 5'b01111);
        sda_dev = '0; tick(8);

        // R7: latency of three rising edges
        scl_dev = 5'b00010; tick(2);
        chk("R7 before third edge", scl_pull, 5'b00000);
        tick(1);
        chk("R7 at third edge", scl_pull, 5'b11101);
        scl_dev = '0; tick(8);

        // R1 R2 R4 R5 vector table
        for (int i = 0; i < 6; i++) begin
            sda_dev = VEC[i][19:15];
            scl_dev = VEC[i][14:10];
            tick(8);
            chk("R2/R4 sda forward", sda_pull, VEC[i][9:5]);
            chk("R1 scl forward", scl_pull, VEC[i][4:0]);
            sda_dev = '0; scl_dev = '0;
            tick(10);
            chk("R5 no lock-up", sda_pull | scl_pull, 5'b00000);
        end

        // R6: contention hands the drive over
        sda_dev = 5'b00001; tick(8);
        sda_dev = 5'b01001; sda_ext = 5'b01000; tick(8);
        chk("R6 two sources", sda_pull, 5'b10110);
        sda_dev = 5'b01000; tick(10);
        chk("R6 held by contender", sda_pull, 5'b10111);
        sda_dev = '0; sda_ext = '0; tick(10);
        chk("R6 release", sda_pull, 5'b00000);

        // R3: disable segment 2 while idle
        stop_seq();
        en_req = 4'b1101; tick(30);
        sda_dev = 5'b00001; tick(8);
        chk("R3 disabled not driven", sda_pull, 5'b11010);
        sda_dev = '0; tick(8);
        sda_dev = 5'b00100; tick(8);
        chk("R3 disabled input ignored", sda_pull, 5'b00000);
        sda_dev = '0; tick(8);

        // R8: request deferred while a line is held low
        scl_dev = 5'b00001; tick(2);
        en_req = 4'b1111; tick(40);
        chk("R8 deferred while busy line", scl_pull, 5'b11010);
        scl_dev = '0; tick(30);
        scl_dev = 5'b00001; tick(8);
        chk("R8 applied after idle", scl_pull, 5'b11110);
        scl_dev = '0; tick(8);

        // R10: open START blocks the enable change until STOP
        sda_dev = 5'b00001; tick(4);
        scl_dev = 5'b00001; tick(4);
        sda_dev = '0; tick(4);
        scl_dev = '0; tick(4);
        en_req = 4'b1101; tick(40);
        scl_dev = 5'b00001; tick(8);
        chk("R10 held by open START", scl_pull, 5'b11110);
        sda_dev = 5'b00001; tick(4);
        scl_dev = '0; tick(8);
        sda_dev = '0; tick(30);
        scl_dev = 5'b00001; tick(8);
        chk("R10 applied after STOP", scl_pull, 5'b11010);
        scl_dev = '0; tick(8);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule